// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core and hands the core one request at a time, together with a vector index. It has five sources: two active-low external pins, two single-cycle timer overflow pulses, and a serial port. The serial port reports a receive-done pulse and a transmit-done pulse. Four byte-wide registers hold the enables, the priorities, the timer and external flags with the external trigger modes, and the serial flags. The core reads them combinationally and writes them through a small register bus.

Each source has an enable bit, and a global enable masks all of them. Each source also has one priority bit that places it on the high level or the low level. Within a level, a fixed order breaks ties. The controller records which levels are in service. It can then let a high-level request interrupt a low-level handler, and hold back every other nesting attempt. An acknowledge strobe starts a handler and a return strobe ends the innermost one.

Top module: `vec_irq_ctrl`

## Requirements
- R1: The register select picks 0 = enable, 1 = priority, 2 = timer/external control, 3 = serial control. In the enable register, bit 7 is the global enable and bits 4:0 enable the sources by vector index: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial. Bits 6:5 read as 0. All registers read 0 after reset.
- R2: While the global enable (enable bit 7) is 0, the request output stays low whatever the other enable bits and flags hold.
- R3: A flagged source whose enable bit is 0 does not raise a request.
- R4: Priority register bit i (same source order as R1) set to 1 puts that source on the high level. A pending high-level source is always chosen over any pending low-level source.
- R5: Among pending sources of the same level, the lowest vector index wins: external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4.
- R6: Control bits 0 and 2 select the trigger mode of external 0 and external 1, where 1 means falling edge. In edge mode a falling pin sets the latched flag (control bit 1 for external 0, bit 3 for external 1) three clocks after the pin changes. The flag stays set after the pin returns high.
- R7: In level mode the external flag follows the inverted synchronized pin three clocks behind it, is not latched, and ignores software writes.
- R8: A timer overflow pulse sets its flag (control bit 5 for timer 0, bit 7 for timer 1) on the next clock. Acknowledging that vector clears the flag.
- R9: The receive-done and transmit-done pulses set serial control bits 0 and 1. The serial source requests while either bit is set. Acknowledge leaves them set, and only a software write clears them.
- R10: A software write to any flag bit takes effect on the next clock. A hardware set of that flag in the same cycle wins over a software clear.
- R11: A high-level request may interrupt a low-level handler. No request is presented while a handler of its own or a higher level is in service.
- R12: Each return strobe ends the highest level in service. A held-back request is presented again once its level is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_n | input | 2 | External interrupt pins, active low, asynchronous |
| tmr_ovf | input | 2 | Timer overflow pulses (bit 0 timer 0, bit 1 timer 1) |
| ser_rx_done | input | 1 | Serial frame received pulse |
| ser_tx_done | input | 1 | Serial frame sent pulse |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 3 | Vector index of the presented request |
| irq_ack | input | 1 | Core accepts the presented request |
| irq_ret | input | 1 | Core returns from the current handler |

## Verification
Register writes, timer pulses, serial pulses, acknowledges and returns all take effect one clock after they are driven. The request and vector follow combinationally from the updated state, so the results are due one clock later. A change on an external pin needs three clocks: two synchronizer stages and the flag register. The bench drives every input on a falling clock edge and samples on a later falling edge, after exactly that number of rising edges. For the pin paths it also samples one clock early, to show the flag is not there yet.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int N_SRC = 5;
  localparam int VEC_W = $clog2(N_SRC);
  localparam int N_EXT = 2;
  localparam int N_TMR = 2;

  typedef enum logic [1:0] {
    SEL_ENA  = 2'd0,
    SEL_PRI  = 2'd1,
    SEL_TCTL = 2'd2,
    SEL_SCTL = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             valid;
    logic             high;
    logic [VEC_W-1:0] idx;
  } arb_res_t;
endpackage

// File: rtl/irq_ext_trig.sv
module irq_ext_trig #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic ack_clr,
  input  logic sw_we,
  input  logic sw_val,
  output logic flag
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;
  logic flag_q, flag_d;
  logic pin_s, fall;

  assign pin_s = sync_q[SYNC_STAGES-1];
  assign fall  = prev_q & ~pin_s;

  always_comb begin
    if (!edge_mode) begin
      flag_d = ~pin_s;
    end else begin
      flag_d = flag_q;
      if (sw_we)   flag_d = sw_val;
      if (ack_clr) flag_d = 1'b0;
      if (fall)    flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      prev_q <= pin_s;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_ctrl_pkg::*;
#(
  parameter int N = N_SRC,
  parameter int W = VEC_W
) (
  input  logic [N-1:0] pend,
  input  logic [N-1:0] high_lvl,
  output arb_res_t     res
);
  logic         hi_v, lo_v;
  logic [W-1:0] hi_idx, lo_idx;

  always_comb begin
    hi_v = 1'b0; lo_v = 1'b0;
    hi_idx = '0; lo_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i] && high_lvl[i]) begin
        hi_v   = 1'b1;
        hi_idx = W'(i);
      end
      if (pend[i]) begin
        lo_v   = 1'b1;
        lo_idx = W'(i);
      end
    end
    res.valid = lo_v;
    res.high  = hi_v;
    res.idx   = hi_v ? hi_idx : lo_idx;
  end
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       take_high,
  input  logic       ret,
  output logic [1:0] in_svc
);
  logic [1:0] svc_q, svc_d;

  always_comb begin
    svc_d = svc_q;
    if (ret) begin
      if (svc_q[1]) svc_d[1] = 1'b0;
      else          svc_d[0] = 1'b0;
    end
    if (take) svc_d[take_high] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= 2'b00;
    else        svc_q <= svc_d;
  end

  assign in_svc = svc_q;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ext_n,
  input  logic [1:0] tmr_ovf,
  input  logic       ser_rx_done,
  input  logic       ser_tx_done,
  input  logic [1:0] reg_sel,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_req,
  output logic [2:0] irq_vec,
  input  logic       irq_ack,
  input  logic       irq_ret
);
  logic             ea_q, ea_d;
  logic [N_SRC-1:0] en_q, en_d, pri_q, pri_d;
  logic [N_EXT-1:0] mode_q, mode_d, ext_flag;
  logic [N_TMR-1:0] tf_q, tf_d;
  logic [1:0]       ser_q, ser_d;
  logic [N_SRC-1:0] pend, masked, ack_hit;
  logic [1:0]       in_svc;
  logic             we_ena, we_pri, we_tctl, we_sctl, level_free, ack_ok;
  arb_res_t         arb;

  assign we_ena  = reg_wr && (reg_sel == SEL_ENA);
  assign we_pri  = reg_wr && (reg_sel == SEL_PRI);
  assign we_tctl = reg_wr && (reg_sel == SEL_TCTL);
  assign we_sctl = reg_wr && (reg_sel == SEL_SCTL);

  always_comb begin
    ea_d   = we_ena  ? reg_wdata[7]           : ea_q;
    en_d   = we_ena  ? reg_wdata[N_SRC-1:0]   : en_q;
    pri_d  = we_pri  ? reg_wdata[N_SRC-1:0]   : pri_q;
    mode_d = we_tctl ? {reg_wdata[2], reg_wdata[0]} : mode_q;
    tf_d   = we_tctl ? {reg_wdata[7], reg_wdata[5]} : tf_q;
    for (int k = 0; k < N_TMR; k++) begin
      if (ack_hit[2*k+1]) tf_d[k] = 1'b0;
      if (tmr_ovf[k])     tf_d[k] = 1'b1;
    end
    ser_d = we_sctl ? reg_wdata[1:0] : ser_q;
    if (ser_rx_done) ser_d[0] = 1'b1;
    if (ser_tx_done) ser_d[1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q   <= 1'b0;
      en_q   <= '0;
      pri_q  <= '0;
      mode_q <= '0;
      tf_q   <= '0;
      ser_q  <= '0;
    end else begin
      ea_q   <= ea_d;
      en_q   <= en_d;
      pri_q  <= pri_d;
      mode_q <= mode_d;
      tf_q   <= tf_d;
      ser_q  <= ser_d;
    end
  end

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    irq_ext_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_n    (ext_n[g]),
      .edge_mode(mode_q[g]),
      .ack_clr  (ack_hit[2*g]),
      .sw_we    (we_tctl),
      .sw_val   (reg_wdata[2*g+1]),
      .flag     (ext_flag[g])
    );
  end

  assign pend   = {|ser_q, tf_q[1], ext_flag[1], tf_q[0], ext_flag[0]};
  assign masked = pend & en_q & {N_SRC{ea_q}};

  irq_arbiter #(.N(N_SRC), .W(VEC_W)) u_arb (
    .pend    (masked),
    .high_lvl(pri_q),
    .res     (arb)
  );

  assign level_free = arb.high ? !in_svc[1] : (in_svc == 2'b00);
  assign irq_req    = arb.valid && level_free;
  assign irq_vec    = arb.idx;
  assign ack_ok     = irq_ack && irq_req;

  for (genvar s = 0; s < N_SRC; s++) begin : g_ack
    assign ack_hit[s] = ack_ok && (arb.idx == VEC_W'(s));
  end

  irq_level_track u_lvl (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (ack_ok),
    .take_high(arb.high),
    .ret      (irq_ret),
    .in_svc   (in_svc)
  );

  always_comb begin
    unique case (reg_sel)
      SEL_ENA:  reg_rdata = {ea_q, 2'b00, en_q};
      SEL_PRI:  reg_rdata = {3'b000, pri_q};
      SEL_TCTL: reg_rdata = {tf_q[1], 1'b0, tf_q[0], 1'b0,
                             ext_flag[1], mode_q[1], ext_flag[0], mode_q[0]};
      default:  reg_rdata = {6'b000000, ser_q};
    endcase
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_req,
  input logic [2:0] irq_vec,
  input logic       irq_ack,
  input logic       irq_ret,
  input logic       ea,
  input logic [4:0] en,
  input logic [1:0] in_svc,
  input logic [1:0] tf,
  input logic [1:0] ser,
  input logic [1:0] tmr_ovf,
  input logic       ser_rx_done,
  input logic       ser_tx_done,
  input logic       reg_wr,
  input logic [1:0] reg_sel
);
  AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !ea |-> !irq_req); // R2
  AST_SRC_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec < 3'd5) && |(en & (5'd1 << irq_vec))); // R3
  AST_TMR_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack && irq_vec == 3'd1 && !tmr_ovf[0] && !(reg_wr && reg_sel == 2'd2))
      |=> !tf[0]); // R8
  AST_SER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack && irq_vec == 3'd4 && !(reg_wr && reg_sel == 2'd3))
      |=> (ser != 2'b00)); // R9
  AST_NO_SAME_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc[1] |-> !irq_req); // R11
  AST_RET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && in_svc[1] && !irq_ack) |=> (!in_svc[1] && in_svc[0] == $past(in_svc[0]))); // R12
  AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ser_rx_done |=> ser[0]); // R10
endmodule

bind vec_irq_ctrl irq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_req    (irq_req),
  .irq_vec    (irq_vec),
  .irq_ack    (irq_ack),
  .irq_ret    (irq_ret),
  .ea         (ea_q),
  .en         (en_q),
  .in_svc     (in_svc),
  .tf         (tf_q),
  .ser        (ser_q),
  .tmr_ovf    (tmr_ovf),
  .ser_rx_done(ser_rx_done),
  .ser_tx_done(ser_tx_done),
  .reg_wr     (reg_wr),
  .reg_sel    (reg_sel)
);

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
  logic       clk, rst_n;
  logic [1:0] ext_n, tmr_ovf, reg_sel;
  logic       ser_rx_done, ser_tx_done, reg_wr, irq_ack, irq_ret, irq_req;
  logic [7:0] reg_wdata, reg_rdata;
  logic [2:0] irq_vec;
  int checks = 0, errors = 0;
  bit done = 0;

  vec_irq_ctrl dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    reg_sel = sel; #1; d = reg_rdata;
  endtask

  task automatic chk_reg(input string req, input logic [1:0] sel, input logic [7:0] exp);
    logic [7:0] d;
    rd(sel, d); chk(req, d, exp);
  endtask

  task automatic chk_irq(input string req, input bit r, input int v);
    #1; chk(req, irq_req, r);
    if (r) chk(req, irq_vec, v);
  endtask

  task automatic ack(); @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0; endtask
  task automatic ret(); @(negedge clk); irq_ret = 1; @(negedge clk); irq_ret = 0; endtask

  // expected {req, vec} with nothing in service
  function automatic logic [3:0] exp_irq(logic [4:0] pend, logic [7:0] en, logic [4:0] pri);
    logic [4:0] m;
    m = pend & en[4:0] & {5{en[7]}};
    if ((m & pri) != 0) m = m & pri;
    for (int i = 0; i < 5; i++) if (m[i]) return {1'b1, 3'(i)};
    return 4'd0;
  endfunction

  initial begin
    tick(200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1dc5));
    rst_n = 0; ext_n = 2'b11; tmr_ovf = 0; reg_sel = 0; reg_wr = 0; reg_wdata = 0;
    ser_rx_done = 0; ser_tx_done = 0; irq_ack = 0; irq_ret = 0;
    tick(3); rst_n = 1; tick(1);
    for (int s = 0; s < 4; s++) chk_reg("R1 reset", 2'(s), 8'h00);
    chk_irq("R1 reset req", 0, 0);
    wr(0, 8'hFF); chk_reg("R1 enable readback", 0, 8'h9F);

    // R8 timer 0 flag and ack
    @(negedge clk); tmr_ovf = 2'b01; @(negedge clk); tmr_ovf = 0;
    chk_reg("R8 tf0 set", 2, 8'h20); chk_irq("R8 req", 1, 1);
    ack(); chk_reg("R8 tf0 ack clear", 2, 8'h00); chk_irq("R8 after ack", 0, 0);
    ret();

    // R2 global enable
    wr(0, 8'h1F);
    @(negedge clk); tmr_ovf = 2'b10; @(negedge clk); tmr_ovf = 0;
    chk_irq("R2 global off", 0, 0);
    wr(0, 8'h97); chk_irq("R3 tmr1 disabled", 0, 0);
    wr(0, 8'h9F); chk_irq("R2 global on", 1, 3);
    wr(2, 8'h00); chk_irq("R10 sw clear tf1", 0, 0);

    // R9 serial
    @(negedge clk); ser_rx_done = 1; @(negedge clk); ser_rx_done = 0;
    chk_reg("R9 rx flag", 3, 8'h01); chk_irq("R9 ser req", 1, 4);
    ack(); chk_reg("R9 kept after ack", 3, 8'h01);
    ret(); wr(3, 8'h00); chk_irq("R9 cleared", 0, 0);
    @(negedge clk); ser_tx_done = 1; @(negedge clk); ser_tx_done = 0;
    chk_reg("R9 tx flag", 3, 8'h02); chk_irq("R9 tx req", 1, 4);
    wr(3, 8'h00);

    // R10 set wins over clear
    @(negedge clk); reg_sel = 3; reg_wr = 1; reg_wdata = 0; ser_rx_done = 1;
    @(negedge clk); reg_wr = 0; ser_rx_done = 0;
    chk_reg("R10 set beats clear", 3, 8'h01);
    wr(3, 8'h00);

    // R6 edge mode
    wr(2, 8'h05);
    @(negedge clk); ext_n[0] = 0;
    tick(2); chk_reg("R6 not yet", 2, 8'h05);
    tick(1); chk_reg("R6 edge flag", 2, 8'h07); chk_irq("R6 req", 1, 0);
    ext_n[0] = 1; tick(4); chk_reg("R6 latched", 2, 8'h07);
    ack(); chk_reg("R6 ack clear", 2, 8'h05); ret();

    // R7 level mode
    wr(2, 8'h00);
    @(negedge clk); ext_n[1] = 0;
    tick(2); chk_reg("R7 not yet", 2, 8'h00);
    tick(1); chk_reg("R7 level flag", 2, 8'h08); chk_irq("R7 req", 1, 2);
    wr(2, 8'h00); chk_reg("R7 sw write ignored", 2, 8'h08);
    @(negedge clk); ext_n[1] = 1; tick(3); chk_reg("R7 follows pin", 2, 8'h00);
    chk_irq("R7 no req", 0, 0);

    // R5 / R4 / R11 / R12
    @(negedge clk); tmr_ovf = 2'b11; ser_rx_done = 1; @(negedge clk); tmr_ovf = 0; ser_rx_done = 0;
    chk_irq("R5 fixed order", 1, 1);
    wr(1, 8'h10); chk_irq("R4 high first", 1, 4);
    ack(); chk_irq("R11 no nest in high", 0, 0);
    ret(); chk_irq("R12 re-presented", 1, 4);
    wr(3, 8'h00); chk_irq("R5 low order", 1, 1);
    ack(); chk_irq("R11 same level held", 0, 0);
    @(negedge clk); ser_rx_done = 1; @(negedge clk); ser_rx_done = 0;
    chk_irq("R11 high preempts low", 1, 4);
    ack(); chk_irq("R11 both in service", 0, 0);
    ret(); chk_irq("R12 high level freed", 1, 4);
    wr(3, 8'h00); chk_irq("R12 low still busy", 0, 0);
    ret(); chk_irq("R12 low freed", 1, 3);
    wr(2, 8'h05); wr(1, 8'h00);

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [7:0] c, e, s, p;
      logic [4:0] pend;
      logic [3:0] x;
      c = 8'h05 | (8'($urandom) & 8'hAA);
      s = 8'($urandom) & 8'h03;
      e = 8'($urandom) & 8'h9F;
      p = 8'($urandom) & 8'h1F;
      wr(2, c); wr(3, s); wr(0, e); wr(1, p);
      pend = {|s[1:0], c[7], c[3], c[5], c[1]};
      x = exp_irq(pend, e, p[4:0]);
      chk_irq("R4 R5 random arbitration", x[3], x[2:0]);
      wr(2, 8'h05); wr(3, 8'h00);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule